// File: doc/BRIEF.md
# Exponent-Binned Exact Floating Point Summer

This block adds a long stream of small floating point values with no rounding at all. Each accepted value is split into a sign, a biased exponent field and a fraction. The fraction gets its hidden bit back, unless the exponent field is zero: that case is a denormal, which counts as exponent 1 with no hidden bit. The resulting integer mantissa is shifted left by the low K exponent bits. It is then added to, or subtracted from, one signed partial-sum register, and the upper exponent bits pick which register. The block records the lowest and highest register that has received a non-zero value.

A pulse on the start input begins a rebuild pass. The pass walks the occupied registers upward, from the lowest to the highest. A running accumulator, one bit wider than a partial sum, adds each register in turn. It emits the low 2^K bits of that sum as one result chunk and shifts right by 2^K. The chunks, least significant first, followed by the signed top word that remains at the end, form the exact two's-complement sum. The result is expressed in units of 2^(2^K · base), where base is the lowest occupied group and is reported alongside the result. A clear flag picks one of two modes. In one mode the registers are zeroed as they are read. In the other they keep their contents, so that later inputs add onto the earlier sums.

Top module: `fp_bin_accum`

## Requirements
- R1: An input is taken on a rising clock edge when `in_valid` and `in_ready` are both high. Its value is ±M·2^E, in units of the fraction LSB. M is {1, `in_frac`} and E is `in_exp` when `in_exp` is non-zero. M is {0, `in_frac`} and E is 1 when `in_exp` is zero. `in_sign` high means negative.
- R2: The register index is E >> K and the left shift applied to M is E mod 2^K. The defaults are K=1, a 4-bit exponent and 8 registers.
- R3: Each partial sum is a signed value of MAN_W+1+2^K+GUARD_W bits. Up to 2^GUARD_W inputs of the largest magnitude can land in one register without wrap-around.
- R4: An input with `in_exp` = 0 and `in_frac` = 0 (either sign) changes no register and no occupancy. A rebuild of a bank that has only seen such inputs behaves as an empty rebuild.
- R5: A rebuild reads the groups from the lowest occupied to the highest occupied, one per cycle. Each cycle gives one `res_valid` beat carrying the low 2^K bits of the running sum, least significant chunk first.
- R6: A rebuild gives exactly hi−lo+1 chunks, where lo and hi are the lowest and highest occupied groups, and it sets `res_base` to lo. (Σ chunk_i·2^(2^K·i) + top·2^(2^K·n)) · 2^(2^K·lo) equals the exact sum of all accepted values. Here n is the chunk count and top is `res_top` read as signed.
- R7: With `rb_clear` high at start, the registers read are zeroed and the occupancy is emptied, so a later rebuild sees only newer inputs. With `rb_clear` low, the contents stay and a later rebuild returns the sum of old and new inputs.
- R8: `in_ready` is high when idle. It is low from the cycle after the start edge until the cycle in which `res_done` is seen. Inputs offered while it is low are not taken.
- R9: `res_done` pulses for one cycle together with the last chunk. A rebuild of an empty bank gives `res_done` with no chunk, `res_top` = 0 and `res_base` = 0.
- R10: An input taken on the same edge that samples `rb_start` is included in that rebuild.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input value offered |
| in_ready | output | 1 | Block can take an input |
| in_sign | input | 1 | Sign of the input, 1 = negative |
| in_exp | input | EXP_W | Biased exponent field |
| in_frac | input | MAN_W | Fraction field without hidden bit |
| rb_start | input | 1 | Start a rebuild pass (taken when idle) |
| rb_clear | input | 1 | Zero the registers while reading them |
| res_valid | output | 1 | A result chunk is present |
| res_chunk | output | 2^K | Result chunk, least significant first |
| res_done | output | 1 | Rebuild finished; marks the last chunk |
| res_top | output | MAN_W+2+2^K+GUARD_W | Signed bits above the last chunk |
| res_base | output | EXP_W−K | Lowest occupied group, the result scale |

## Verification
The accumulate path and the rebuild sequencer can both act in one cycle. A value can be taken on the same edge that samples `rb_start`, and an input can be offered while the walk is running. The bench drives a value together with the start pulse and checks that the rebuilt sum contains it. It also holds `in_valid` high with a non-zero value through a whole clearing pass, and then checks that a following rebuild finds the bank empty. Every rebuilt chunk stream is compared with an exact integer sum that the bench builds from ±M·2^E.

// File: rtl/fp_bin_pkg.sv
package fp_bin_pkg;
  typedef enum logic [1:0] {RB_IDLE, RB_ARM, RB_WALK} rb_state_t;
endpackage

// File: rtl/fp_bin_unpack.sv
module fp_bin_unpack #(
  parameter int EXP_W = 4,
  parameter int MAN_W = 3,
  parameter int K     = 1,
  parameter int PS_W  = 14
) (
  input  logic                   sign,
  input  logic [EXP_W-1:0]       exp_f,
  input  logic [MAN_W-1:0]       frac,
  output logic [EXP_W-K-1:0]     grp,
  output logic [PS_W-1:0]        addend,
  output logic                   nonzero
);
  localparam int MNT_W = MAN_W + 1;

  function automatic logic [EXP_W-1:0] eff_exp(input logic [EXP_W-1:0] e);
    return (e == '0) ? EXP_W'(1) : e;
  endfunction

  function automatic logic [MNT_W-1:0] full_mant(input logic [EXP_W-1:0] e,
                                                 input logic [MAN_W-1:0] f);
    return {(e != '0), f};
  endfunction

  function automatic logic [PS_W-1:0] place(input logic [MNT_W-1:0] m,
                                            input logic [K-1:0] sh);
    return {{(PS_W-MNT_W){1'b0}}, m} << sh;
  endfunction

  logic [EXP_W-1:0] e_eff;
  logic [PS_W-1:0]  placed;

  always_comb begin
    e_eff   = eff_exp(exp_f);
    grp     = e_eff[EXP_W-1:K];
    placed  = place(full_mant(exp_f, frac), e_eff[K-1:0]);
    addend  = sign ? (~placed + 1'b1) : placed;
    nonzero = (exp_f != '0) || (frac != '0);
  end
endmodule

// File: rtl/fp_bin_bank.sv
module fp_bin_bank #(
  parameter int GRP_W = 3,
  parameter int PS_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [GRP_W-1:0]  wr_grp,
  input  logic [PS_W-1:0]   wr_val,
  input  logic [GRP_W-1:0]  rd_idx,
  input  logic              clr_en,
  input  logic              range_clear,
  output logic [PS_W-1:0]   rd_data,
  output logic              has_data,
  output logic [GRP_W-1:0]  gmin,
  output logic [GRP_W-1:0]  gmax
);
  localparam int NG = 1 << GRP_W;

  logic [PS_W-1:0] ps [NG];
  logic [PS_W-1:0] wr_sel;
  logic [PS_W:0]   wr_wide;

  assign rd_data = ps[rd_idx];
  assign wr_sel  = ps[wr_grp];
  assign wr_wide = {wr_sel[PS_W-1], wr_sel} + {wr_val[PS_W-1], wr_val};

  always_ff @(posedge clk) begin
    for (int g = 0; g < NG; g++) begin
      if (!rst_n)
        ps[g] <= '0;
      else if (clr_en && rd_idx == GRP_W'(g))
        ps[g] <= '0;
      else if (wr_en && wr_grp == GRP_W'(g))
        ps[g] <= ps[g] + wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      has_data <= 1'b0;
      gmin     <= '0;
      gmax     <= '0;
    end else if (range_clear) begin
      has_data <= 1'b0;
    end else if (wr_en) begin
      has_data <= 1'b1;
      if (!has_data || wr_grp < gmin) gmin <= wr_grp;
      if (!has_data || wr_grp > gmax) gmax <= wr_grp;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_wide[PS_W] == wr_wide[PS_W-1])); // R3
  AST_RANGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    has_data |-> (gmin <= gmax)); // R6
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (ps[$past(rd_idx)] == '0)); // R7
endmodule

// File: rtl/fp_bin_rebuild.sv
module fp_bin_rebuild
  import fp_bin_pkg::*;
#(
  parameter int GRP_W = 3,
  parameter int PS_W  = 14,
  parameter int CH_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                clear_req,
  input  logic                has_data,
  input  logic [GRP_W-1:0]    gmin,
  input  logic [GRP_W-1:0]    gmax,
  input  logic [PS_W-1:0]     rd_data,
  output logic                busy,
  output logic [GRP_W-1:0]    rd_idx,
  output logic                clr_en,
  output logic                range_clear,
  output logic                chunk_valid,
  output logic [CH_W-1:0]     chunk,
  output logic                done,
  output logic [PS_W:0]       top,
  output logic [GRP_W-1:0]    base
);
  localparam int ACC_W = PS_W + 1;

  rb_state_t               state;
  logic [GRP_W-1:0]        idx, last_g;
  logic                    clear_mode;
  logic signed [ACC_W-1:0] racc, sum;
  logic                    walking, at_last;

  assign walking     = (state == RB_WALK);
  assign busy        = (state != RB_IDLE);
  assign at_last     = walking && (idx == last_g);
  assign rd_idx      = walking ? idx : '0;
  assign clr_en      = walking && clear_mode;
  assign range_clear = at_last && clear_mode;
  assign sum         = racc + $signed({rd_data[PS_W-1], rd_data});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= RB_IDLE;
      idx         <= '0;
      last_g      <= '0;
      clear_mode  <= 1'b0;
      racc        <= '0;
      chunk_valid <= 1'b0;
      chunk       <= '0;
      done        <= 1'b0;
      top         <= '0;
      base        <= '0;
    end else begin
      chunk_valid <= 1'b0;
      done        <= 1'b0;
      case (state)
        RB_IDLE: if (start) begin
          state      <= RB_ARM;
          clear_mode <= clear_req;
        end
        RB_ARM: begin
          racc <= '0;
          if (has_data) begin
            state  <= RB_WALK;
            idx    <= gmin;
            last_g <= gmax;
            base   <= gmin;
          end else begin
            state <= RB_IDLE;
            done  <= 1'b1;
            top   <= '0;
            base  <= '0;
          end
        end
        default: begin
          chunk_valid <= 1'b1;
          chunk       <= sum[CH_W-1:0];
          racc        <= sum >>> CH_W;
          idx         <= idx + 1'b1;
          if (at_last) begin
            state <= RB_IDLE;
            done  <= 1'b1;
            top   <= sum >>> CH_W;
          end
        end
      endcase
    end
  end

  AST_WALK_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (walking && $past(walking)) |-> (idx == $past(idx) + 1'b1)); // R5
  AST_DONE_ENDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == RB_IDLE)); // R9
  AST_CHUNK_FROM_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> $past(walking)); // R5
endmodule

// File: rtl/fp_bin_accum.sv
module fp_bin_accum #(
  parameter int EXP_W   = 4,
  parameter int MAN_W   = 3,
  parameter int K       = 1,
  parameter int GUARD_W = 8,
  localparam int CH_W   = 1 << K,
  localparam int GRP_W  = EXP_W - K,
  localparam int PS_W   = MAN_W + 1 + CH_W + GUARD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MAN_W-1:0]  in_frac,
  input  logic              rb_start,
  input  logic              rb_clear,
  output logic              res_valid,
  output logic [CH_W-1:0]   res_chunk,
  output logic              res_done,
  output logic [PS_W:0]     res_top,
  output logic [GRP_W-1:0]  res_base
);
  logic [GRP_W-1:0] in_grp, rd_idx, gmin, gmax;
  logic [PS_W-1:0]  addend, rd_data;
  logic             nonzero, wr_en, busy, clr_en, range_clear, has_data;
  logic             take;

  assign in_ready = !busy;
  assign take     = in_valid && in_ready;
  assign wr_en    = take && nonzero;

  fp_bin_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .K(K), .PS_W(PS_W)) u_unpack (
    .sign(in_sign), .exp_f(in_exp), .frac(in_frac),
    .grp(in_grp), .addend(addend), .nonzero(nonzero));

  fp_bin_bank #(.GRP_W(GRP_W), .PS_W(PS_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(in_grp), .wr_val(addend),
    .rd_idx(rd_idx), .clr_en(clr_en), .range_clear(range_clear),
    .rd_data(rd_data), .has_data(has_data), .gmin(gmin), .gmax(gmax));

  fp_bin_rebuild #(.GRP_W(GRP_W), .PS_W(PS_W), .CH_W(CH_W)) u_rebuild (
    .clk(clk), .rst_n(rst_n), .start(rb_start), .clear_req(rb_clear),
    .has_data(has_data), .gmin(gmin), .gmax(gmax), .rd_data(rd_data),
    .busy(busy), .rd_idx(rd_idx), .clr_en(clr_en), .range_clear(range_clear),
    .chunk_valid(res_valid), .chunk(res_chunk), .done(res_done),
    .top(res_top), .base(res_base));

  AST_ZERO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !nonzero) |=> ($stable(has_data) && $stable(gmin) && $stable(gmax))); // R4
  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rb_start && in_ready) |-> !in_ready); // R8
endmodule

// File: tb/sim_fp_bin_accum.sv
module sim_fp_bin_accum;
  localparam int EXP_W = 4, MAN_W = 3, K = 1, GUARD_W = 8;
  localparam int CH_W = 1 << K, GRP_W = EXP_W - K;
  localparam int PS_W = MAN_W + 1 + CH_W + GUARD_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sign = 1'b0, rb_start = 1'b0, rb_clear = 1'b0;
  logic [EXP_W-1:0] in_exp = '0;
  logic [MAN_W-1:0] in_frac = '0;
  logic in_ready, res_valid, res_done;
  logic [CH_W-1:0] res_chunk;
  logic [PS_W:0] res_top;
  logic [GRP_W-1:0] res_base;

  int nrun = 0, nfail = 0;
  longint ref_sum = 0;
  int ref_lo = 0, ref_hi = 0;
  bit ref_any = 1'b0;

  always #10 clk = ~clk;

  fp_bin_accum #(.EXP_W(EXP_W), .MAN_W(MAN_W), .K(K), .GUARD_W(GUARD_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_frac(in_frac),
    .rb_start(rb_start), .rb_clear(rb_clear), .res_valid(res_valid),
    .res_chunk(res_chunk), .res_done(res_done), .res_top(res_top),
    .res_base(res_base));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic note_ref(input bit s, input int e, input int f);
    int ee, m, g;
    if (e == 0 && f == 0) return;
    ee = (e == 0) ? 1 : e;
    m  = (e == 0) ? f : (f + (1 << MAN_W));
    g  = ee >> K;
    ref_sum += s ? -(longint'(m) << ee) : (longint'(m) << ee);
    if (!ref_any || g < ref_lo) ref_lo = g;
    if (!ref_any || g > ref_hi) ref_hi = g;
    ref_any = 1'b1;
  endtask

  task automatic put(input bit s, input int e, input int f);
    in_valid = 1'b1; in_sign = s; in_exp = EXP_W'(e); in_frac = MAN_W'(f);
    @(negedge clk);
    in_valid = 1'b0;
    note_ref(s, e, f);
  endtask

  // same: drive an input with the start pulse; poke: offer an input during the pass
  task automatic rebuild(input bit clr, input bit same, input bit poke,
                         input bit s, input int e, input int f, input string req);
    longint val = 0;
    int n = 0;
    bit ready_bad = 1'b0, got_done = 1'b0;
    rb_start = 1'b1; rb_clear = clr;
    if (same) begin
      in_valid = 1'b1; in_sign = s; in_exp = EXP_W'(e); in_frac = MAN_W'(f);
      note_ref(s, e, f);
    end
    @(negedge clk);
    rb_start = 1'b0; in_valid = 1'b0;
    for (int it = 0; it < 40; it++) begin
      if (res_valid) begin
        val += longint'(res_chunk) << (CH_W * n);
        n++;
      end
      if (res_done) begin
        got_done = 1'b1;
        in_valid = 1'b0;
        val += longint'($signed(res_top)) <<< (CH_W * n);
        break;
      end
      if (in_ready) ready_bad = 1'b1;
      if (poke) begin
        in_valid = 1'b1; in_sign = 1'b0; in_exp = 4'd9; in_frac = 3'd6;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(got_done, "R9 done seen", got_done, 1);
    chk(!ready_bad, "R8 ready low during pass", ready_bad, 0);
    if (ref_any) begin
      val = val <<< (CH_W * int'(res_base));
      chk(val == ref_sum, {req, " R6 exact sum"}, val, ref_sum);
      chk(n == ref_hi - ref_lo + 1, {req, " R5 chunk count"}, n, ref_hi - ref_lo + 1);
      chk(int'(res_base) == ref_lo, {req, " R6 base group"}, res_base, ref_lo);
    end else begin
      chk(n == 0 && val == 0 && res_base == '0, {req, " R9 empty pass"}, val + n, 0);
    end
    if (clr) begin
      ref_sum = 0; ref_any = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 reset ready", in_ready, 1);
    chk(res_valid == 1'b0 && res_done == 1'b0, "R9 reset outputs", res_valid, 0);

    // R1 R2: every non-zero code alone
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 16; e++)
        for (int f = 0; f < 8; f++) begin
          if (e == 0 && f == 0) continue;
          put(s[0], e, f);
          rebuild(1'b1, 1'b0, 1'b0, 0, 0, 0, "R1 R2 single");
        end

    // R6 random streams
    for (int t = 0; t < 30; t++) begin
      for (int i = 0; i < 40; i++)
        put($urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(0, 7));
      rebuild(1'b1, 1'b0, 1'b0, 0, 0, 0, "R6 random");
    end

    // R4 zero inputs only
    put(0, 0, 0); put(1, 0, 0); put(0, 0, 0);
    rebuild(1'b1, 1'b0, 1'b0, 0, 0, 0, "R4 zeros");

    // R4 zero mixed with a value
    put(0, 6, 3); put(1, 0, 0);
    rebuild(1'b1, 1'b0, 1'b0, 0, 0, 0, "R4 zero mixed");

    // R6 cancellation: exact zero over one group
    put(0, 9, 5); put(1, 9, 5);
    rebuild(1'b1, 1'b0, 1'b0, 0, 0, 0, "R6 cancel");

    // R7 keep mode then clear mode
    put(0, 3, 1); put(1, 12, 7); put(0, 7, 2);
    rebuild(1'b0, 1'b0, 1'b0, 0, 0, 0, "R7 keep first");
    put(0, 1, 4); put(0, 15, 0);
    rebuild(1'b1, 1'b0, 1'b0, 0, 0, 0, "R7 keep total");
    rebuild(1'b1, 1'b0, 1'b0, 0, 0, 0, "R7 cleared bank");

    // R10 input together with start
    put(0, 4, 2);
    rebuild(1'b1, 1'b1, 1'b0, 1, 11, 3, "R10 same cycle");
    rebuild(1'b1, 1'b1, 1'b0, 0, 14, 6, "R10 same cycle alone");

    // R8 input offered during a clearing pass is not taken
    put(0, 2, 1); put(0, 13, 4);
    rebuild(1'b1, 1'b0, 1'b1, 0, 0, 0, "R8 poke pass");
    rebuild(1'b1, 1'b0, 1'b0, 0, 0, 0, "R8 after poke");

    // R3 many largest magnitudes in one group
    for (int i = 0; i < 250; i++) put(0, 15, 7);
    rebuild(1'b1, 1'b0, 1'b0, 0, 0, 0, "R3 positive load");
    for (int i = 0; i < 250; i++) put(1, 14, 7);
    rebuild(1'b1, 1'b0, 1'b0, 0, 0, 0, "R3 negative load");

    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule